// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers words from an asynchronous serial line. The line is brought into the clock domain through a two-flop synchronizer. A falling edge on an idle line starts a frame. From that point a counter, set by the integer parameter `CLKS_PER_BIT`, finds the middle of each bit slot. The received bits are shifted into a word, and the block reports three results: the word with a one-cycle valid pulse, a framing-error pulse and a parity-error pulse.

Software, or a neighbouring block, sets the frame format through static inputs. These inputs select the word length (5 to 9 bits), the bit order, one of five parity modes, whether parity errors are reported, and whether the line is inverted. The format inputs must be held steady while a frame is in progress. The `line_invert` input may be changed together with the line itself while the receiver is idle.

Top module: `uart_frame_rx`

## Requirements
- R1: The start of a frame is a falling edge of the line. With `line_invert`=1 the start is a rising edge, and every bit sampled from the line is complemented. The inversion is applied ahead of the synchronizer, so changing `line_invert` together with the line level while idle does not start a frame.
- R2: Let the line's start edge be presented just after rising edge c. Slot n is sampled on rising edge c + 3 + CLKS_PER_BIT/2 + n·CLKS_PER_BIT, using integer division. The 3 covers two synchronizer stages and one edge-detect stage. Slot 0 is the start bit, slots 1..N are the data bits, and the next slot is the parity bit if parity is used, otherwise the stop bit.
- R3: If the start bit sampled at mid-slot is 1 (after inversion), `frame_err` pulses for one cycle, no word is delivered, and the receiver waits for the next start edge.
- R4: `data_bits` selects N from 5 to 9. The word appears in `rx_word[N-1:0]`, and the bits above N-1 are 0.
- R5: With `msb_first`=0 the first data bit received becomes `rx_word[0]`. With `msb_first`=1 it becomes `rx_word[N-1]`.
- R6: `rx_valid` is high for exactly one cycle, in the cycle after the last data bit is sampled. `rx_word` changes only together with that pulse and otherwise holds its value.
- R7: `parity_mode` encoding: 0 none, 1 odd, 2 even, 3 always-zero, 4 always-one. Values 5 to 7 behave as none. In odd mode the count of ones in the data bits plus the parity bit must be odd, and in even mode it must be even. In always-zero mode the parity bit must be 0, and in always-one mode it must be 1. A violation pulses `parity_err` for one cycle after the parity slot.
- R8: When no parity is used, there is no parity slot: the slot after the last data bit is the stop bit, and `parity_err` never pulses.
- R9: With `parity_check_en`=0 the parity slot is still consumed, but `parity_err` stays low.
- R10: A stop bit sampled as 0 pulses `frame_err` for one cycle after the stop slot. The word has already been delivered, and the receiver returns to idle whether the stop bit is 0 or 1.
- R11: After reset all three strobes are low and `rx_word` is 0. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous serial input |
| line_invert | input | 1 | 1: line is inverted (idle low) |
| data_bits | input | 4 | Word length N, 5 to 9 |
| msb_first | input | 1 | 1: the first data bit is the MSB |
| parity_mode | input | 3 | 0 none, 1 odd, 2 even, 3 always-zero, 4 always-one |
| parity_check_en | input | 1 | 1: report parity violations |
| rx_word | output | 9 | Last received word, zero-extended |
| rx_valid | output | 1 | One-cycle pulse: `rx_word` is new |
| frame_err | output | 1 | One-cycle pulse: bad start or stop bit |
| parity_err | output | 1 | One-cycle pulse: parity violation |

## Verification
The bench builds the receiver with `CLKS_PER_BIT`=7. This odd width makes the half-slot offset round (7/2 = 3), so an error in the mid-slot arithmetic shifts every sample instant by a cycle. A two-cycle low glitch then falls cleanly on the wrong side of the start-bit sample point. The bench stores the expected clock-edge number with every word and strobe, which ties the exact position of every slot to R2. At 7 clocks per bit, a 9-bit frame with parity lasts about 80 cycles, so every combination of word length, bit order, parity mode and inversion fits in a short run.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       line_invert,
  input  logic [3:0] data_bits,
  input  logic       msb_first,
  input  logic [2:0] parity_mode,
  input  logic       parity_check_en,
  output logic [8:0] rx_word,
  output logic       rx_valid,
  output logic       frame_err,
  output logic       parity_err
);
  localparam int DW   = 9;
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int CW   = $clog2(CLKS_PER_BIT + 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} state_t;

  state_t          state;
  logic [1:0]      sync;
  logic            s_prev;
  logic [CW-1:0]   cnt;
  logic [3:0]      bitn;
  logic [DW-1:0]   sh;

  wire s    = sync[1];
  wire fall = s_prev & ~s;
  wire tick = (state == START) ? (cnt == CW'(HALF)) : (cnt == CW'(CLKS_PER_BIT));
  wire has_par = (parity_mode >= 3'd1) && (parity_mode <= 3'd4);
  wire last_bit = (bitn == data_bits - 4'd1);

  wire [DW-1:0] sh_next = msb_first ? {sh[DW-2:0], s}
                                    : ((sh >> 1) | (DW'(s) << (data_bits - 4'd1)));

  logic par_ok;
  always_comb begin
    case (parity_mode)
      3'd1:    par_ok = (^{sh, s}) == 1'b1;
      3'd2:    par_ok = (^{sh, s}) == 1'b0;
      3'd3:    par_ok = (s == 1'b0);
      3'd4:    par_ok = (s == 1'b1);
      default: par_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= IDLE;
      sync       <= 2'b11;
      s_prev     <= 1'b1;
      cnt        <= CW'(1);
      bitn       <= '0;
      sh         <= '0;
      rx_word    <= '0;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      sync       <= {sync[0], line_in ^ line_invert};
      s_prev     <= s;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
      if (state != IDLE)
        cnt <= tick ? CW'(1) : cnt + CW'(1);
      case (state)
        IDLE: if (fall) begin
          state <= START;
          cnt   <= CW'(1);
        end
        START: if (tick) begin
          if (s) begin
            frame_err <= 1'b1;
            state     <= IDLE;
          end else begin
            state <= DATA;
            bitn  <= '0;
            sh    <= '0;
          end
        end
        DATA: if (tick) begin
          sh <= sh_next;
          if (last_bit) begin
            rx_word  <= sh_next;
            rx_valid <= 1'b1;
            state    <= has_par ? PAR : STOP;
          end else begin
            bitn <= bitn + 4'd1;
          end
        end
        PAR: if (tick) begin
          if (parity_check_en && !par_ok) parity_err <= 1'b1;
          state <= STOP;
        end
        STOP: if (tick) begin
          if (!s) frame_err <= 1'b1;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word));

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, frame_err, parity_err}));

  a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> $past(parity_check_en));

  a_r8_no_parity_slot: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> ($past(parity_mode) >= 3'd1 && $past(parity_mode) <= 3'd4));

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && (cnt <= CW'(CLKS_PER_BIT)));
endmodule

// File: tb/uart_frame_rx_test.sv
module uart_frame_rx_test;
  localparam int W = 7;
  localparam int H = W / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = 1'b1;
  logic       line_invert = 1'b0;
  logic [3:0] data_bits = 4'd8;
  logic       msb_first = 1'b0;
  logic [2:0] parity_mode = 3'd0;
  logic       parity_check_en = 1'b1;
  logic [8:0] rx_word;
  logic       rx_valid, frame_err, parity_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int    qk[$];
  int    qw[$];
  int    qc[$];
  string qr[$];

  uart_frame_rx #(.CLKS_PER_BIT(W)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_invert(line_invert),
    .data_bits(data_bits), .msb_first(msb_first), .parity_mode(parity_mode),
    .parity_check_en(parity_check_en), .rx_word(rx_word), .rx_valid(rx_valid),
    .frame_err(frame_err), .parity_err(parity_err)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int k, int w, int c, string r);
    qk.push_back(k); qw.push_back(w); qc.push_back(c); qr.push_back(r);
  endtask

  // kinds: 0 word, 1 framing error, 2 parity error
  task automatic take(int k, int w);
    int ek, ew, ec;
    string er;
    checks++;
    if (qk.size() == 0) begin
      errors++;
      $display("FAIL R11 unexpected event kind=%0d word=%h cyc=%0d expected none", k, w, cyc);
    end else begin
      ek = qk.pop_front(); ew = qw.pop_front(); ec = qc.pop_front(); er = qr.pop_front();
      if (ek != k || ew != w || ec != cyc) begin
        errors++;
        $display("FAIL %s kind=%0d word=%h cyc=%0d expected kind=%0d word=%h cyc=%0d",
                 er, k, w, cyc, ek, ew, ec);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid)   take(0, int'(rx_word));
      if (parity_err) take(2, 0);
      if (frame_err)  take(1, 0);
    end
  end

  task automatic drive(bit b);
    line_in = b ^ line_invert;
    repeat (W) @(negedge clk);
  endtask

  task automatic send(int word, int n, int pm, bit msb, bit inv, bit chk,
                      bit flip, bit stopv, string req);
    int t0, hp, mask, pbit, ones;
    @(negedge clk);
    data_bits = 4'(n); parity_mode = 3'(pm); msb_first = msb;
    line_invert = inv; line_in = inv ? 1'b0 : 1'b1; parity_check_en = chk;
    repeat (3) @(negedge clk);
    mask = (1 << n) - 1;
    word = word & mask;
    hp = (pm >= 1 && pm <= 4) ? 1 : 0;
    ones = $countones(word);
    case (pm)
      1: pbit = (ones % 2 == 0) ? 1 : 0;
      2: pbit = ones % 2;
      4: pbit = 1;
      default: pbit = 0;
    endcase
    if (flip) pbit = pbit ^ 1;
    t0 = cyc;
    push(0, word, t0 + 3 + H + n * W, req);
    if (hp == 1 && chk && flip) push(2, 0, t0 + 3 + H + (n + 1) * W, req);
    if (!stopv) push(1, 0, t0 + 3 + H + (n + 1 + hp) * W, req);
    drive(1'b0);
    for (int i = 0; i < n; i++) drive(msb ? word[n-1-i] : word[i]);
    if (hp == 1) drive(pbit[0]);
    drive(stopv);
    line_in = inv ? 1'b0 : 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rx_word !== 9'd0 || rx_valid !== 1'b0 || frame_err !== 1'b0 || parity_err !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset word=%h v=%b fe=%b pe=%b expected all zero",
               rx_word, rx_valid, frame_err, parity_err);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send('hA5, 8, 0, 0, 0, 1, 0, 1, "R2");   // R2 R8 plain 8-bit, no parity
    send('h3C, 8, 1, 0, 0, 1, 0, 1, "R7");   // odd parity, good
    send('h7F, 8, 2, 0, 0, 1, 0, 1, "R7");   // even parity, good
    send('h13, 5, 0, 1, 0, 1, 0, 1, "R5");   // R4 5-bit msb-first
    send('h1A5, 9, 2, 0, 0, 1, 0, 1, "R4");  // 9-bit even
    send('h55, 7, 4, 0, 0, 1, 0, 1, "R7");   // always-one good
    send('h2A, 6, 3, 0, 0, 1, 0, 1, "R7");   // always-zero good
    send('h0F, 8, 1, 0, 0, 1, 1, 1, "R7");   // odd parity corrupted
    send('h40, 7, 3, 0, 0, 1, 1, 1, "R7");   // always-zero corrupted
    send('hC3, 8, 2, 0, 0, 0, 1, 1, "R9");   // corrupted but check disabled
    send('h99, 8, 0, 0, 0, 1, 0, 0, "R10");  // bad stop, word still delivered
    send('h81, 8, 1, 1, 0, 1, 0, 1, "R5");   // msb-first odd
    send('h5A, 8, 2, 0, 1, 1, 0, 1, "R1");   // inverted line
    send('h1F3, 9, 0, 1, 1, 1, 0, 0, "R1");  // inverted, msb, bad stop

    // R3 glitch on the start bit, plain line
    begin
      int t0;
      @(negedge clk);
      line_invert = 1'b0; line_in = 1'b1;
      repeat (3) @(negedge clk);
      t0 = cyc;
      push(1, 0, t0 + 3 + H, "R3");
      line_in = 1'b0;
      repeat (2) @(negedge clk);
      line_in = 1'b1;
      repeat (3 * W) @(negedge clk);
    end
    send('h66, 8, 0, 0, 0, 1, 0, 1, "R3");   // recovers after glitch

    repeat (20) @(negedge clk);
    checks++;
    if (qk.size() != 0) begin
      errors++;
      $display("FAIL R6 missing events count=%0d expected 0", qk.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule